// File: doc/BRIEF.md
# Stack Frame Save/Restore Sequencer

This block executes one compact procedure-frame instruction found in the compressed (16-bit) instruction stream. When a valid 16-bit word arrives with an odd fetch address and carries the frame-instruction signature, the block decodes three packed fields:

- how many argument registers to spill;
- how many callee-saved registers to save or restore;
- whether the return-address register takes part.

It then walks through a variable-length series of 32-bit stack stores (entry form) or stack loads (exit form). Every frame it builds or removes is exactly 32 bytes.

The block reads and writes the register file through one read port and one write port. It talks to memory over a single-outstanding request/acknowledge interface. The entry form moves the stack pointer down by 32. The exit form moves the stack pointer up by 32 and then redirects the PC to the return address. Any word that does not qualify leaves the block on a one-cycle reserved-instruction output for the normal exception path. A misaligned stack address stops the sequence and reports an address error, tagged as store or load.

Top module: `frame_seq_top`

## Requirements
- R1: A word is accepted only when `insn_valid` is high, `busy` is low, `pc_odd` is 1 and `(insn_word & 16'hF81F) == 16'hE809`. Any other word presented while idle raises `rsvd_pass` in the same cycle and starts nothing.
- R2: The fields are decoded from the word as follows. `insn_word[10:8]` is the argument count A; the value 7 selects the exit form and 0 to 4 select the entry form. `insn_word[7:6]` is the saved count S. `insn_word[5]` is the return-address flag F. The words with A=5, A=6 or S=3 are not executed; they raise `rsvd_pass` instead.
- R3: The entry form first stores registers 4, 5, … (A of them), in ascending order. Register 4+i goes to address SP+4·i, where SP is the value of register 29 at the start.
- R4: The entry form then writes register 29 with SP−32. This happens after the argument stores and before any further store.
- R5: The entry form then stores downward from SP in 4-byte steps. Register 31 goes first if F=1. Registers 16, 17, … (S of them) follow in ascending order.
- R6: The exit form loads downward from SP+32 in 4-byte steps. Register 31 is loaded first if F=1, then registers 16, 17, … (S of them) in ascending order. Each loaded word is sign-extended from bit 31 to the register width.
- R7: After its loads, the exit form writes register 29 with SP+32. It then writes the PC with the value register 31 holds at that point, which may be the value just loaded.
- R8: No access is issued to an address whose bits [1:0] are nonzero. At the first such access the sequence ends with `done` and `addr_err` both high. `err_store` is 1 for the entry form and 0 for the exit form. No later register-29 or PC write takes place.
- R9: `mem_req` is a one-cycle pulse carrying a word-aligned address. No new request is issued before the acknowledge for the previous one.
- R10: `busy` rises in the cycle after acceptance and stays high through the `done` cycle. It is low in the cycle after that. While busy, new strobes are ignored and `rsvd_pass` stays low.
- R11: In and just after reset, `busy`, `done`, `mem_req`, `rf_wr_en` and `pc_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word strobe |
| insn_word | input | 16 | Compressed instruction word |
| pc_odd | input | 1 | Bit 0 of the fetch address (compressed mode) |
| rsvd_pass | output | 1 | Word handed on as a reserved instruction |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| addr_err | output | 1 | Sequence ended on a misaligned address |
| err_store | output | 1 | Address error was on a store (entry form) |
| rf_rd_addr | output | 5 | Register file read index |
| rf_rd_data | input | XLEN | Register file read data, same cycle |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_addr | output | 5 | Register file write index |
| rf_wr_data | output | XLEN | Register file write data |
| mem_req | output | 1 | Memory word request pulse |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Response to the outstanding request |
| mem_rdata | input | 32 | Load data, valid with `mem_ack` |
| pc_wr_en | output | 1 | PC redirect strobe |
| pc_wr_data | output | XLEN | New PC value |

## Verification
The assertions take for granted a few things about the environment:

- `mem_ack` arrives only while a request is outstanding.
- The register-file read port answers combinationally in the cycle the index is driven.
- A register write becomes visible on that read port from the next cycle.

The bench memory model acknowledges each request exactly once, after a random delay of one to three cycles, and it counts any request made while another is pending. Stack pointers are drawn from a window that keeps the whole frame inside the modelled memory. Misaligned pointers are injected on purpose only to exercise the address-error path.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  localparam int ADDR_W      = 32;
  localparam int WORD_W      = 32;
  localparam int FRAME_BYTES = 32;
  localparam int WORD_BYTES  = 4;

  localparam logic [15:0] SIG_MASK = 16'hF81F;
  localparam logic [15:0] SIG_VAL  = 16'hE809;

  localparam logic [2:0] NARGS_EXIT = 3'd7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GETSP,
    ST_ARG,
    ST_SPDN,
    ST_RA,
    ST_SREG,
    ST_SPUP,
    ST_PC,
    ST_DONE
  } seq_st_e;

  typedef struct packed {
    logic [2:0] nargs;
    logic [1:0] nsav;
    logic       keep_ra;
    logic       is_exit;
  } frame_t;

  // Byte address touched by the current memory step.
  function automatic logic [ADDR_W-1:0] slot_addr(
    input seq_st_e           st,
    input logic [ADDR_W-1:0] sp,
    input frame_t            f,
    input logic [2:0]        idx
  );
    logic [ADDR_W-1:0] top;
    top = f.is_exit ? sp + ADDR_W'(FRAME_BYTES) : sp;
    case (st)
      ST_ARG:  return sp + (ADDR_W'(idx) << 2);
      ST_RA:   return top - ADDR_W'(WORD_BYTES);
      ST_SREG: return top - ((ADDR_W'(idx) + ADDR_W'(f.keep_ra) + ADDR_W'(1)) << 2);
      default: return sp;
    endcase
  endfunction

  // Step that follows the last beat of step `cur`; empty steps are skipped.
  function automatic seq_st_e seq_next(input seq_st_e cur, input frame_t f);
    case (cur)
      ST_GETSP: begin
        if (f.is_exit)
          return f.keep_ra ? ST_RA : ((f.nsav != 2'd0) ? ST_SREG : ST_SPUP);
        else
          return (f.nargs != 3'd0) ? ST_ARG : ST_SPDN;
      end
      ST_ARG:  return ST_SPDN;
      ST_SPDN: return f.keep_ra ? ST_RA : ((f.nsav != 2'd0) ? ST_SREG : ST_DONE);
      ST_RA: begin
        if (f.nsav != 2'd0) return ST_SREG;
        return f.is_exit ? ST_SPUP : ST_DONE;
      end
      ST_SREG: return f.is_exit ? ST_SPUP : ST_DONE;
      ST_SPUP: return ST_PC;
      ST_PC:   return ST_DONE;
      default: return ST_IDLE;
    endcase
  endfunction

  function automatic logic is_mem_step(input seq_st_e st);
    return (st == ST_ARG) || (st == ST_RA) || (st == ST_SREG);
  endfunction

endpackage

// File: rtl/fsq_decode.sv
module fsq_decode
  import fsq_pkg::*;
(
  input  logic        insn_valid,
  input  logic [15:0] insn_word,
  input  logic        pc_odd,
  input  logic        busy,
  output logic        accept,
  output logic        rsvd_pass,
  output frame_t      frame
);

  logic sig_hit;
  logic bad_field;
  logic take;

  assign sig_hit   = pc_odd && ((insn_word & SIG_MASK) == SIG_VAL);
  assign bad_field = (insn_word[10:8] == 3'd5) || (insn_word[10:8] == 3'd6) ||
                     (insn_word[7:6] == 2'd3);
  assign take      = insn_valid && !busy;

  assign accept    = take && sig_hit && !bad_field;
  assign rsvd_pass = take && !(sig_hit && !bad_field);

  always_comb begin
    frame.nargs   = insn_word[10:8];
    frame.nsav    = insn_word[7:6];
    frame.keep_ra = insn_word[5];
    frame.is_exit = (insn_word[10:8] == NARGS_EXIT);
  end

endmodule

// File: rtl/fsq_ctrl.sv
module fsq_ctrl
  import fsq_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int RIDX_W   = 5,
  parameter int SP_IDX   = 29,
  parameter int RA_IDX   = 31,
  parameter int ARG_BASE = 4,
  parameter int SAV_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  frame_t            start_frame,
  output logic              busy,
  output logic              done,
  output logic              addr_err,
  output logic              err_store,
  output logic [RIDX_W-1:0] rf_rd_addr,
  input  logic [XLEN-1:0]   rf_rd_data,
  output logic              rf_wr_en,
  output logic [RIDX_W-1:0] rf_wr_addr,
  output logic [XLEN-1:0]   rf_wr_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              pc_wr_en,
  output logic [XLEN-1:0]   pc_wr_data
);

  localparam logic [XLEN-1:0]   FRAME_X = XLEN'(FRAME_BYTES);
  localparam logic [RIDX_W-1:0] SP_R    = RIDX_W'(SP_IDX);
  localparam logic [RIDX_W-1:0] RA_R    = RIDX_W'(RA_IDX);

  function automatic logic [XLEN-1:0] sext_word(input logic [WORD_W-1:0] w);
    return XLEN'(signed'(w));
  endfunction

  seq_st_e           st_q;
  frame_t            f_q;
  logic [2:0]        idx_q;
  logic [XLEN-1:0]   sp_q;
  logic              wait_q;
  logic              err_q;

  // Named internal events
  logic [ADDR_W-1:0] step_addr;
  logic              mem_step;
  logic              misalign;
  logic              issue;
  logic              resp;
  logic              step_last;
  logic [RIDX_W-1:0] step_reg;
  seq_st_e           st_after;

  assign step_addr = slot_addr(st_q, sp_q[ADDR_W-1:0], f_q, idx_q);
  assign mem_step  = is_mem_step(st_q);
  assign misalign  = mem_step && !wait_q && (step_addr[1:0] != 2'b00);
  assign issue     = mem_step && !wait_q && !misalign;
  assign resp      = mem_step && wait_q && mem_ack;
  assign st_after  = seq_next(st_q, f_q);

  always_comb begin
    case (st_q)
      ST_ARG:  step_last = (idx_q == (f_q.nargs - 3'd1));
      ST_SREG: step_last = (idx_q == {1'b0, f_q.nsav - 2'd1});
      default: step_last = 1'b1;
    endcase
  end

  always_comb begin
    case (st_q)
      ST_GETSP: step_reg = SP_R;
      ST_ARG:   step_reg = RIDX_W'(ARG_BASE) + RIDX_W'(idx_q);
      ST_RA:    step_reg = RA_R;
      ST_SREG:  step_reg = RIDX_W'(SAV_BASE) + RIDX_W'(idx_q);
      ST_PC:    step_reg = RA_R;
      ST_SPDN:  step_reg = SP_R;
      ST_SPUP:  step_reg = SP_R;
      default:  step_reg = '0;
    endcase
  end

  // Port-facing outputs
  assign busy       = (st_q != ST_IDLE);
  assign done       = (st_q == ST_DONE);
  assign addr_err   = done && err_q;
  assign err_store  = done && err_q && !f_q.is_exit;

  assign rf_rd_addr = step_reg;
  assign mem_req    = issue;
  assign mem_we     = !f_q.is_exit;
  assign mem_addr   = step_addr;
  assign mem_wdata  = rf_rd_data[WORD_W-1:0];

  assign pc_wr_en   = (st_q == ST_PC);
  assign pc_wr_data = rf_rd_data;

  always_comb begin
    rf_wr_en   = 1'b0;
    rf_wr_addr = step_reg;
    rf_wr_data = sext_word(mem_rdata);
    case (st_q)
      ST_SPDN: begin
        rf_wr_en   = 1'b1;
        rf_wr_data = sp_q - FRAME_X;
      end
      ST_SPUP: begin
        rf_wr_en   = 1'b1;
        rf_wr_data = sp_q + FRAME_X;
      end
      default: rf_wr_en = resp && f_q.is_exit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      f_q    <= '0;
      idx_q  <= '0;
      sp_q   <= '0;
      wait_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q   <= ST_GETSP;
            f_q    <= start_frame;
            idx_q  <= '0;
            wait_q <= 1'b0;
            err_q  <= 1'b0;
          end
        end
        ST_GETSP: begin
          sp_q <= rf_rd_data;
          st_q <= st_after;
        end
        ST_ARG, ST_RA, ST_SREG: begin
          if (misalign) begin
            err_q <= 1'b1;
            st_q  <= ST_DONE;
          end else if (issue) begin
            wait_q <= 1'b1;
          end else if (resp) begin
            wait_q <= 1'b0;
            if (step_last) begin
              idx_q <= '0;
              st_q  <= st_after;
            end else begin
              idx_q <= idx_q + 3'd1;
            end
          end
        end
        ST_SPDN, ST_SPUP, ST_PC: st_q <= st_after;
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // A request is a single-cycle pulse: R9
  p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // Environment: a response only answers an outstanding request (R9)
  p_ack_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack |-> wait_q);

  // Every issued address is word aligned: R8
  p_req_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // An address error only appears as the closing beat: R8
  p_err_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> done);

  // The PC redirect is the last action before a clean finish: R7
  p_pc_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_en |=> (done && !addr_err));

  // The stack-pointer update never overlaps a memory request: R4
  p_sp_write_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_en && (rf_wr_addr == SP_R)) |-> !mem_req);

endmodule

// File: rtl/frame_seq_top.sv
module frame_seq_top
  import fsq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [15:0]       insn_word,
  input  logic              pc_odd,
  output logic              rsvd_pass,
  output logic              busy,
  output logic              done,
  output logic              addr_err,
  output logic              err_store,
  output logic [4:0]        rf_rd_addr,
  input  logic [XLEN-1:0]   rf_rd_data,
  output logic              rf_wr_en,
  output logic [4:0]        rf_wr_addr,
  output logic [XLEN-1:0]   rf_wr_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              pc_wr_en,
  output logic [XLEN-1:0]   pc_wr_data
);

  logic   accept;
  frame_t dec_frame;

  fsq_decode u_decode (
    .insn_valid (insn_valid),
    .insn_word  (insn_word),
    .pc_odd     (pc_odd),
    .busy       (busy),
    .accept     (accept),
    .rsvd_pass  (rsvd_pass),
    .frame      (dec_frame)
  );

  fsq_ctrl #(
    .XLEN     (XLEN),
    .RIDX_W   (5),
    .SP_IDX   (29),
    .RA_IDX   (31),
    .ARG_BASE (4),
    .SAV_BASE (16)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_frame (dec_frame),
    .busy        (busy),
    .done        (done),
    .addr_err    (addr_err),
    .err_store   (err_store),
    .rf_rd_addr  (rf_rd_addr),
    .rf_rd_data  (rf_rd_data),
    .rf_wr_en    (rf_wr_en),
    .rf_wr_addr  (rf_wr_addr),
    .rf_wr_data  (rf_wr_data),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .pc_wr_en    (pc_wr_en),
    .pc_wr_data  (pc_wr_data)
  );

  // A sequence only starts from a qualifying word: R1
  p_start_sig_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(insn_valid && pc_odd && ((insn_word & SIG_MASK) == SIG_VAL)));

  // Illegal field values never start a sequence: R2
  p_start_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past((insn_word[10:8] != 3'd5) && (insn_word[10:8] != 3'd6) &&
                          (insn_word[7:6] != 2'd3)));

  // Busy holds until done, then drops: R10
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // No pass-on while a sequence runs: R10
  p_rsvd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_pass |-> !busy);

endmodule

// File: tb/frame_seq_top_tb_top.sv
module frame_seq_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN       = 32;
  localparam int LOG_DEPTH  = 4096;

  localparam logic [1:0] K_ST = 2'd0;
  localparam logic [1:0] K_LD = 2'd1;
  localparam logic [1:0] K_RW = 2'd2;
  localparam logic [1:0] K_PC = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic            insn_valid = 1'b0;
  logic [15:0]     insn_word = '0;
  logic            pc_odd = 1'b0;
  logic            rsvd_pass, busy, done, addr_err, err_store;
  logic [4:0]      rf_rd_addr, rf_wr_addr;
  logic [XLEN-1:0] rf_rd_data, rf_wr_data, pc_wr_data;
  logic            rf_wr_en, mem_req, mem_we, pc_wr_en;
  logic [31:0]     mem_addr, mem_wdata;
  logic            mem_ack = 1'b0;
  logic [31:0]     mem_rdata = '0;

  frame_seq_top #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .pc_odd(pc_odd), .rsvd_pass(rsvd_pass), .busy(busy), .done(done),
    .addr_err(addr_err), .err_store(err_store), .rf_rd_addr(rf_rd_addr),
    .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr),
    .rf_wr_data(rf_wr_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data)
  );

  // Register file and memory models
  logic [31:0] rf  [32];
  logic [31:0] mem [1024];
  assign rf_rd_data = rf[rf_rd_addr];

  logic        pend = 1'b0;
  logic [1:0]  lat = '0;
  logic [31:0] pend_addr = '0;
  int          proto_bad = 0;

  logic [1:0]  ev_k [LOG_DEPTH];
  logic [31:0] ev_a [LOG_DEPTH];
  logic [31:0] ev_d [LOG_DEPTH];
  int          ev_n = 0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (!rst_n) begin
      pend <= 1'b0;
    end else begin
      if (pend) begin
        if (lat == 2'd0) begin
          mem_ack   <= 1'b1;
          mem_rdata <= mem[pend_addr[11:2]];
          pend      <= 1'b0;
        end else begin
          lat <= lat - 2'd1;
        end
      end
      if (mem_req) begin
        if (pend) proto_bad <= proto_bad + 1;
        pend      <= 1'b1;
        lat       <= 2'($urandom % 3);
        pend_addr <= mem_addr;
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        ev_k[ev_n] <= mem_we ? K_ST : K_LD;
        ev_a[ev_n] <= mem_addr;
        ev_d[ev_n] <= mem_we ? mem_wdata : 32'd0;
        ev_n       <= ev_n + 1;
      end else if (rf_wr_en) begin
        rf[rf_wr_addr] <= rf_wr_data;
        ev_k[ev_n] <= K_RW;
        ev_a[ev_n] <= 32'(rf_wr_addr);
        ev_d[ev_n] <= rf_wr_data;
        ev_n       <= ev_n + 1;
      end else if (pc_wr_en) begin
        ev_k[ev_n] <= K_PC;
        ev_a[ev_n] <= 32'd0;
        ev_d[ev_n] <= pc_wr_data;
        ev_n       <= ev_n + 1;
      end
    end
  end

  // Checking
  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  // Expected-behaviour model
  logic [1:0]  x_k [64];
  logic [31:0] x_a [64];
  logic [31:0] x_d [64];
  int          x_n;
  bit          x_acc, x_err, x_st;

  function automatic logic [15:0] mk(input int a, input int s, input int r);
    return {5'b11101, 3'(a), 2'(s), 1'(r), 5'b01001};
  endfunction

  task automatic push(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d);
    x_k[x_n] = k; x_a[x_n] = a; x_d[x_n] = d; x_n++;
  endtask

  task automatic build_exp(input logic [15:0] w, input logic odd);
    int a, s;
    bit r;
    logic [31:0] sp, t, v;
    logic [31:0] m [32];
    a = int'(w[10:8]); s = int'(w[7:6]); r = w[5];
    for (int i = 0; i < 32; i++) m[i] = rf[i];
    x_n = 0; x_err = 1'b0;
    x_acc = odd && ((w & 16'hF81F) == 16'hE809) && (a != 5) && (a != 6) && (s != 3);
    x_st  = (a != 7);
    if (!x_acc) return;
    sp = m[29];
    if (a != 7) begin
      for (int i = 0; i < a; i++) begin
        t = sp + 32'(4 * i);
        if (t[1:0] != 2'b00) begin x_err = 1'b1; return; end
        push(K_ST, t, m[4 + i]);
      end
      push(K_RW, 32'd29, sp - 32'd32);
      t = sp;
      if (r) begin
        t = t - 32'd4;
        if (t[1:0] != 2'b00) begin x_err = 1'b1; return; end
        push(K_ST, t, m[31]);
      end
      for (int i = 0; i < s; i++) begin
        t = t - 32'd4;
        if (t[1:0] != 2'b00) begin x_err = 1'b1; return; end
        push(K_ST, t, m[16 + i]);
      end
    end else begin
      t = sp + 32'd32;
      if (r) begin
        t = t - 32'd4;
        if (t[1:0] != 2'b00) begin x_err = 1'b1; return; end
        v = mem[t[11:2]];
        push(K_LD, t, 32'd0);
        push(K_RW, 32'd31, v);
        m[31] = v;
      end
      for (int i = 0; i < s; i++) begin
        t = t - 32'd4;
        if (t[1:0] != 2'b00) begin x_err = 1'b1; return; end
        v = mem[t[11:2]];
        push(K_LD, t, 32'd0);
        push(K_RW, 32'(16 + i), v);
      end
      push(K_RW, 32'd29, sp + 32'd32);
      push(K_PC, 32'd0, m[31]);
    end
  endtask

  task automatic set_regs(input logic [31:0] sp);
    for (int i = 0; i < 32; i++) rf[i] = $urandom;
    rf[29] = sp;
  endtask

  // Drive one word; optionally strobe another word mid-sequence.
  task automatic run_insn(input logic [15:0] w, input logic odd, input bit poke);
    int base, n;
    string tag;
    build_exp(w, odd);
    if (x_err) tag = "R8";
    else if (!x_acc) tag = "R1 R2";
    else if (x_st) tag = "R3 R4 R5";
    else tag = "R6 R7";
    base = ev_n;
    @(negedge clk);
    insn_valid = 1'b1; insn_word = w; pc_odd = odd;
    #1;
    chk(rsvd_pass == !x_acc, "R1 R2 rsvd_pass", 32'(rsvd_pass), 32'(!x_acc));
    chk(busy == 1'b0, "R10 idle before accept", 32'(busy), 32'd0);
    @(negedge clk);
    insn_valid = 1'b0;
    if (!x_acc) begin
      chk(busy == 1'b0, "R1 R2 no start", 32'(busy), 32'd0);
      @(negedge clk);
      chk(ev_n == base, "R1 R2 no activity", 32'(ev_n - base), 32'd0);
      return;
    end
    chk(busy == 1'b1, "R10 busy after accept", 32'(busy), 32'd1);
    n = 0;
    while (!done && n < 300) begin
      if (poke && n == 1) begin
        insn_valid = 1'b1; insn_word = mk(7, 2, 1); pc_odd = 1'b1;
        #1;
        chk(rsvd_pass == 1'b0, "R10 strobe ignored", 32'(rsvd_pass), 32'd0);
      end
      @(negedge clk);
      insn_valid = 1'b0;
      n++;
    end
    chk(done == 1'b1, "R10 done reached", 32'(done), 32'd1);
    chk(busy == 1'b1, "R10 busy with done", 32'(busy), 32'd1);
    chk(addr_err == x_err, "R8 addr_err", 32'(addr_err), 32'(x_err));
    chk(err_store == (x_err && x_st), "R8 err_store", 32'(err_store), 32'(x_err && x_st));
    @(negedge clk);
    chk(busy == 1'b0, "R10 busy drops", 32'(busy), 32'd0);
    chk(ev_n - base == x_n, {tag, " event count"}, 32'(ev_n - base), 32'(x_n));
    if (ev_n - base == x_n) begin
      for (int i = 0; i < x_n; i++) begin
        chk(ev_k[base + i] == x_k[i], {tag, " event kind"}, 32'(ev_k[base + i]), 32'(x_k[i]));
        chk(ev_a[base + i] == x_a[i], {tag, " event addr"}, ev_a[base + i], x_a[i]);
        chk(ev_d[base + i] == x_d[i], {tag, " event data"}, ev_d[base + i], x_d[i]);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    set_regs(32'h0000_0800);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(busy == 1'b0, "R11 busy in reset", 32'(busy), 32'd0);
    chk(done == 1'b0, "R11 done in reset", 32'(done), 32'd0);
    chk(mem_req == 1'b0, "R11 mem_req in reset", 32'(mem_req), 32'd0);
    chk(rf_wr_en == 1'b0 && pc_wr_en == 1'b0, "R11 writes in reset",
        32'({rf_wr_en, pc_wr_en}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R11 busy after reset", 32'(busy), 32'd0);

    // Directed corner cases
    set_regs(32'h0000_0800); run_insn(mk(4, 2, 1), 1'b1, 1'b0); // R3 R4 R5 full entry
    set_regs(32'h0000_0840); run_insn(mk(0, 0, 0), 1'b1, 1'b0); // R4 bare frame
    set_regs(32'h0000_0900); run_insn(mk(2, 0, 1), 1'b1, 1'b0); // R3 R5
    set_regs(32'h0000_0800); run_insn(mk(7, 2, 1), 1'b1, 1'b0); // R6 R7 full exit
    set_regs(32'h0000_0880); run_insn(mk(7, 1, 0), 1'b1, 1'b0); // R6 R7 old RA to PC
    set_regs(32'h0000_0880); run_insn(mk(7, 0, 0), 1'b1, 1'b0); // R7 no loads
    set_regs(32'h0000_0800); run_insn(mk(5, 0, 0), 1'b1, 1'b0); // R2 illegal
    set_regs(32'h0000_0800); run_insn(mk(6, 1, 1), 1'b1, 1'b0); // R2 illegal
    set_regs(32'h0000_0800); run_insn(mk(1, 3, 0), 1'b1, 1'b0); // R2 illegal
    set_regs(32'h0000_0800); run_insn(mk(1, 1, 1), 1'b0, 1'b0); // R1 even PC
    set_regs(32'h0000_0800); run_insn(mk(1, 1, 1) ^ 16'h0010, 1'b1, 1'b0); // R1 mask
    set_regs(32'h0000_0802); run_insn(mk(2, 1, 1), 1'b1, 1'b0); // R8 store error
    set_regs(32'h0000_0801); run_insn(mk(0, 1, 1), 1'b1, 1'b0); // R8 after SP write
    set_regs(32'h0000_0803); run_insn(mk(7, 1, 1), 1'b1, 1'b0); // R8 load error
    set_regs(32'h0000_0803); run_insn(mk(0, 0, 0), 1'b1, 1'b0); // R8 no access, no error
    set_regs(32'h0000_0810); run_insn(mk(3, 2, 1), 1'b1, 1'b1); // R10 strobe while busy

    // Constrained random
    for (int k = 0; k < 60; k++) begin
      logic [31:0] sp;
      logic [15:0] w;
      logic odd;
      sp = 32'h0000_0800 + 32'(4 * ($urandom % 64));
      if ($urandom % 8 == 0) sp = sp + 32'(1 + $urandom % 3);
      set_regs(sp);
      odd = 1'b1;
      if ($urandom % 6 == 0) begin
        w = 16'($urandom);
        odd = 1'($urandom);
      end else begin
        w = mk(int'($urandom % 8), int'($urandom % 4), int'($urandom % 2));
      end
      run_insn(w, odd, ($urandom % 5) == 0);
    end

    repeat (4) @(negedge clk);
    chk(proto_bad == 0, "R9 single outstanding request", 32'(proto_bad), 32'd0);
    finish_run();
  end

endmodule